// File: doc/BRIEF.md
# Auto-Reload Down-Counting Timer Channel

A single timer channel with a 32-bit down counter, a reload register and a control register. A free-running prescaler produces count ticks from the peripheral clock, dividing by 4, 16, 64, 256 or 1024. The ratio is chosen by a 3-bit code in the control register. The counter decrements on each tick while the external run input is high. On a tick at a count of zero, the counter reloads from the reload register and sets a sticky underflow flag. When the underflow interrupt enable is set, that flag drives the interrupt line.

Software reaches the channel through a word-indexed register port. Writes are strobed and reads are combinational. Index 0 is the reload register, index 1 the counter, index 2 the control register and index 3 a capture slot. The capture slot reads zero and ignores writes. Software clears the underflow flag by writing 0 to its control bit. Writing 1 to that bit leaves the flag as it is.

Top module: `tmr_channel`

## Requirements
- R1: After reset the reload register and the counter read 0xFFFFFFFF, the control register reads 0, and irq_o is low.
- R2: Control bits [2:0] hold the prescaler code. Codes 0, 1, 2, 3 and 4 make the counter decrement once every 4, 16, 64, 256 and 1024 clock cycles while run_i is high.
- R3: While run_i is low the counter holds its value and no underflow occurs.
- R4: A tick that arrives at a count of 0 loads the reload value into the counter and sets the underflow flag, which reads back in control bit 8, in the same cycle.
- R5: A reload write does not change the current count. It supplies the value used at the next underflow.
- R6: A counter write (index 1) loads the new count on the write edge. It takes precedence over a tick in the same cycle.
- R7: A control write with bit 8 equal to 0 clears the underflow flag. A control write with bit 8 equal to 1 keeps the flag unchanged.
- R8: irq_o is high exactly when the underflow flag is set and control bit 5 (interrupt enable) is set.
- R9: A control write with prescaler code 5, 6 or 7 keeps the previous code. Only bits [2:0], 5 and 8 of the control register can read as 1. Bit 9 and bits [15:10] always read 0.
- R10: A control write restarts the prescaler. The first tick after the write comes one full selected period after the write edge.
- R11: Index 3 always reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Channel run enable |
| we_i | input | 1 | Register write strobe |
| idx_i | input | 2 | Register index (0 reload, 1 count, 2 control, 3 capture) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for idx_i |
| irq_o | output | 1 | Underflow interrupt |

## Verification
The bench builds the channel with its default parameters: a 32-bit counter and five prescaler codes. These defaults make the reset value of all ones observable. They also keep the longest divide-by-1024 period short enough to measure edge by edge, so all five codes are timed against their exact first and second tick. Small reload and count values then bring the zero-count underflow, the reload hand-off and the flag-clear rules within a few dozen cycles. Two further checks are placed on exact edges: the prescaler restart on a mid-period control write, and a counter write on the same edge as a possible tick.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CODE_W   = 3;
  localparam int unsigned UIE_BIT  = 5;
  localparam int unsigned UF_BIT   = 8;

  typedef enum logic [1:0] {
    REG_RELOAD = 2'd0,
    REG_COUNT  = 2'd1,
    REG_CTRL   = 2'd2,
    REG_CAPT   = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_CODES = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              restart_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);
  localparam int unsigned DIV_W = 2 * NUM_CODES;
  localparam int unsigned SLOTS = 2 ** CODE_W;

  logic [DIV_W-1:0] div_q;
  logic [SLOTS-1:0] hit;

  for (genvar g = 0; g < SLOTS; g++) begin : g_hit
    if (g < NUM_CODES) begin : g_valid
      assign hit[g] = &div_q[2*g+1:0];
    end else begin : g_rsvd
      assign hit[g] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        div_q <= '0;
    else if (restart_i) div_q <= '0;
    else if (run_i)     div_q <= div_q + 1'b1;
  end

  // control writes pause counting for that cycle
  assign tick_o = run_i && !restart_i && hit[code_i];

  assert_no_tick_stopped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !tick_o);
  assert_restart_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !tick_o);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             reload_we_i,
  input  logic [CNT_W-1:0] reload_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             uf_o
);
  logic [CNT_W-1:0] cnt_q, reload_q;

  assign uf_o = tick_i && !load_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '1;
      reload_q <= '1;
    end else begin
      if (reload_we_i) reload_q <= reload_val_i;
      if (load_i)      cnt_q <= load_val_i;
      else if (uf_o)   cnt_q <= reload_q;
      else if (tick_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o    = cnt_q;
  assign reload_o = reload_q;

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_q));
  assert_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && cnt_q == '0) |=> cnt_q == $past(reload_q));
  assert_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));
endmodule

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_CODES = 5,
  parameter int unsigned DATA_W    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              uf_set_i,
  output logic [CODE_W-1:0] code_o,
  output logic              uie_o,
  output logic              uf_o
);
  logic [CODE_W-1:0] code_q;
  logic              uie_q, uf_q;
  logic [CODE_W-1:0] wcode;

  assign wcode = wdata_i[CODE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      uie_q  <= 1'b0;
      uf_q   <= 1'b0;
    end else begin
      if (we_i) begin
        uie_q <= wdata_i[UIE_BIT];
        if (32'(wcode) < NUM_CODES) code_q <= wcode;
      end
      if (we_i && !wdata_i[UF_BIT]) uf_q <= 1'b0;
      else if (uf_set_i)            uf_q <= 1'b1;
    end
  end

  assign code_o = code_q;
  assign uie_o  = uie_q;
  assign uf_o   = uf_q;

  assert_code_legal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(code_q) < NUM_CODES);
  assert_flag_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uf_q && !(we_i && !wdata_i[UF_BIT])) |=> uf_q);
  assert_flag_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uf_set_i && !we_i) |=> uf_q);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned NUM_CODES = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             we_i,
  input  logic [1:0]       idx_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             irq_o
);
  reg_idx_e          idx;
  logic              we_reload, we_count, we_ctrl;
  logic              tick, uf_pulse;
  logic [CODE_W-1:0] code;
  logic              uie, uf;
  logic [CNT_W-1:0]  cnt, reload, ctrl_rd;

  assign idx       = reg_idx_e'(idx_i);
  assign we_reload = we_i && (idx == REG_RELOAD);
  assign we_count  = we_i && (idx == REG_COUNT);
  assign we_ctrl   = we_i && (idx == REG_CTRL);

  tmr_prescaler #(.NUM_CODES(NUM_CODES)) u_presc (
    .clk_i, .rst_ni, .run_i,
    .restart_i (we_ctrl),
    .code_i    (code),
    .tick_o    (tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .tick_i       (tick),
    .load_i       (we_count),
    .load_val_i   (wdata_i),
    .reload_we_i  (we_reload),
    .reload_val_i (wdata_i),
    .cnt_o        (cnt),
    .reload_o     (reload),
    .uf_o         (uf_pulse)
  );

  tmr_ctrl_reg #(.NUM_CODES(NUM_CODES), .DATA_W(CNT_W)) u_ctrl (
    .clk_i, .rst_ni,
    .we_i     (we_ctrl),
    .wdata_i  (wdata_i),
    .uf_set_i (uf_pulse),
    .code_o   (code),
    .uie_o    (uie),
    .uf_o     (uf)
  );

  always_comb begin
    ctrl_rd                = '0;
    ctrl_rd[CODE_W-1:0]    = code;
    ctrl_rd[UIE_BIT]       = uie;
    ctrl_rd[UF_BIT]        = uf;
  end

  always_comb begin
    unique case (idx)
      REG_RELOAD: rdata_o = reload;
      REG_COUNT:  rdata_o = cnt;
      REG_CTRL:   rdata_o = ctrl_rd;
      default:    rdata_o = '0;
    endcase
  end

  assign irq_o = uf && uie;

  assert_irq_needs_enable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ctrl_rd[UIE_BIT] && ctrl_rd[UF_BIT]));
  assert_irq_rises_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uf_pulse && uie && !we_i) |=> irq_o);
endmodule

// File: tb/tmr_channel_tb.sv
module tmr_channel_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_i = 1'b0;
  logic        we_i = 1'b0;
  logic [1:0]  idx_i = 2'd0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tmr_channel u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .run_i(run_i), .we_i(we_i),
    .idx_i(idx_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    we_i = 1'b1; idx_i = idx; wdata_i = d;
    @(negedge clk);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] idx, output logic [31:0] d);
    idx_i = idx;
    #1;
    d = rdata_o;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(0, v); chk("R1 reload", v, 32'hFFFF_FFFF);
    rd(1, v); chk("R1 count", v, 32'hFFFF_FFFF);
    rd(2, v); chk("R1 ctrl", v, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_prescale(input int code);
    logic [31:0] v;
    int per;
    per = 4 ** (code + 1);
    run_i = 1'b0;
    wr(2, code);
    wr(1, 32'd1000);
    run_i = 1'b1;
    repeat (per - 1) @(negedge clk);
    rd(1, v); chk($sformatf("R2 code%0d before tick", code), v, 32'd1000);
    @(negedge clk);
    rd(1, v); chk($sformatf("R2 code%0d first tick", code), v, 32'd999);
    repeat (per) @(negedge clk);
    rd(1, v); chk($sformatf("R2 code%0d second tick", code), v, 32'd998);
    run_i = 1'b0;
  endtask

  task automatic t_stopped;
    logic [31:0] v;
    run_i = 1'b0;
    wr(2, 32'h0);
    wr(0, 32'd3);
    wr(1, 32'd0);
    repeat (50) @(negedge clk);
    rd(1, v); chk("R3 count held", v, 32'd0);
    rd(2, v); chk("R3 no underflow", v, 32'h0);
  endtask

  task automatic t_underflow;
    logic [31:0] v;
    run_i = 1'b0;
    wr(2, 32'h20);
    wr(0, 32'd5);
    wr(1, 32'd1);
    run_i = 1'b1;
    repeat (7) @(negedge clk);
    rd(1, v); chk("R4 at zero", v, 32'd0);
    chk("R8 irq before", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    run_i = 1'b0;
    rd(1, v); chk("R4 reloaded", v, 32'd5);
    rd(2, v); chk("R4 flag set", v, 32'h120);
    chk("R8 irq raised", {31'b0, irq_o}, 32'h1);
    wr(2, 32'h120);
    rd(2, v); chk("R7 write 1 keeps flag", v, 32'h120);
    wr(2, 32'h100);
    chk("R8 irq masked", {31'b0, irq_o}, 32'h0);
    rd(2, v); chk("R7 flag kept, enable off", v, 32'h100);
    wr(2, 32'h020);
    rd(2, v); chk("R7 write 0 clears", v, 32'h020);
    chk("R8 irq off after clear", {31'b0, irq_o}, 32'h0);
    wr(2, 32'h0);
  endtask

  task automatic t_reload;
    logic [31:0] v;
    run_i = 1'b0;
    wr(2, 32'h0);
    wr(1, 32'd2);
    wr(0, 32'd7);
    rd(1, v); chk("R5 count untouched", v, 32'd2);
    wr(0, 32'd9);
    run_i = 1'b1;
    repeat (12) @(negedge clk);
    run_i = 1'b0;
    rd(1, v); chk("R5 latest reload used", v, 32'd9);
    wr(2, 32'h0);
  endtask

  task automatic t_count_write;
    logic [31:0] v;
    run_i = 1'b0;
    wr(2, 32'h0);
    wr(1, 32'd40);
    run_i = 1'b1;
    repeat (2) @(negedge clk);
    // write edge is the 4th running edge, where a tick falls
    @(negedge clk);
    we_i = 1'b1; idx_i = 2'd1; wdata_i = 32'd50;
    @(negedge clk);
    we_i = 1'b0;
    run_i = 1'b0;
    rd(1, v); chk("R6 write wins over tick", v, 32'd50);
  endtask

  task automatic t_reserved;
    logic [31:0] v;
    run_i = 1'b0;
    wr(2, 32'h2);
    wr(2, 32'hFC05);
    rd(2, v); chk("R9 code 5 ignored, high bits zero", v, 32'h2);
    wr(2, 32'h2C6);
    rd(2, v); chk("R9 code 6 ignored, bit 9 zero", v, 32'h2);
    wr(2, 32'h27);
    rd(2, v); chk("R9 code 7 ignored", v, 32'h22);
    wr(2, 32'h0);
  endtask

  task automatic t_restart;
    logic [31:0] v;
    run_i = 1'b0;
    wr(2, 32'h0);
    wr(1, 32'd100);
    run_i = 1'b1;
    @(negedge clk);
    wr(2, 32'h0);
    repeat (3) @(negedge clk);
    rd(1, v); chk("R10 no early tick", v, 32'd100);
    @(negedge clk);
    rd(1, v); chk("R10 full period after write", v, 32'd99);
    run_i = 1'b0;
  endtask

  task automatic t_capture;
    logic [31:0] v;
    run_i = 1'b0;
    wr(0, 32'h11);
    wr(1, 32'h22);
    wr(2, 32'h23);
    wr(3, 32'h1234_5678);
    rd(3, v); chk("R11 capture reads 0", v, 32'h0);
    rd(0, v); chk("R11 reload untouched", v, 32'h11);
    rd(1, v); chk("R11 count untouched", v, 32'h22);
    rd(2, v); chk("R11 ctrl untouched", v, 32'h23);
    wr(2, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    for (int c = 0; c < 5; c++) t_prescale(c);
    t_stopped();
    t_underflow();
    t_reload();
    t_count_write();
    t_reserved();
    t_restart();
    t_capture();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
    $finish;
  end
endmodule